// File: doc/BRIEF.md
# Multi-Mode Timer/Event Counter

This block is a reloadable up-counter with three counting sources. In interval mode it counts ticks of the system clock after a power-of-two prescaler. In event mode it counts edges on an external input, and the counting edge is selectable. In pulse-width mode it counts prescaled system-clock ticks while the external input is away from its idle level. When the pulse ends, the block clears its own run bit, so it measures a single pulse per arm.

When the counter reaches its all-ones value, the next count reloads it from a preload register and counting carries on. This happens in every mode. Each overflow pulses a wake-up output. The interrupt output pulses only when its enable is set. Software programs the mode, the prescaler, the edge, the run bit and the interrupt enable in one configuration write. It loads the preload value through a separate write and reads the counter and the run bit back on output ports. A power-down flag stops the internal-clock modes, but event counting carries on, so an external event can still wake the system.

Top module: `tmr_evt_unit`

## Requirements
- R1: The mode field `cfgMode` is decoded as follows: 2'b10 selects interval mode, 2'b01 selects event mode and 2'b11 selects pulse-width mode. With 2'b00 the counter holds its value even when run is set.
- R2: In interval mode with prescaler select `cfgPsc`=p, the counter advances once every 2^p system clocks. The first advance comes 2^p clocks after the configuration write that sets run.
- R3: The counter changes only while `runBit` is 1, except through a preload write. In interval and event modes only a configuration write clears `runBit`.
- R4: A count from 8'hFF loads the counter with the preload value and does not wrap to zero. This holds in all modes.
- R5: Each overflow gives a one-cycle `wakeReq` pulse. `irqReq` pulses in the same cycle only when `cfgIrqEn` was written as 1.
- R6: In event mode with `cfgEdge`=0, each rising edge of `extPin` adds one and falling edges are ignored. With `cfgEdge`=1, each falling edge adds one and rising edges are ignored.
- R7: In pulse-width mode with `cfgEdge`=0, a low pulse of W clocks on `extPin` adds floor(W/2^p). With `cfgEdge`=1, a high pulse of W clocks adds floor(W/2^p).
- R8: At the end of a measured pulse the hardware clears `runBit`. The counter then holds, and later pulses are ignored until run is written again.
- R9: While `pdFlag` is 1, interval and pulse-width counting halt. Event counting and its overflow wake-up continue.
- R10: A preload write while `runBit` is 0 also loads the counter. While `runBit` is 1 it changes only the preload value.
- R11: After reset the counter, preload, `runBit`, `irqReq` and `wakeReq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdFlag | input | 1 | Power-down flag |
| extPin | input | 1 | External event / pulse input, asynchronous |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Mode select |
| cfgPsc | input | 3 | Prescaler select, ratio 2^cfgPsc |
| cfgEdge | input | 1 | Edge / polarity select |
| cfgRun | input | 1 | Run bit value written |
| cfgIrqEn | input | 1 | Overflow interrupt enable |
| preWe | input | 1 | Preload write strobe |
| preData | input | 8 | Preload value |
| cntVal | output | 8 | Counter readback |
| runBit | output | 1 | Run bit readback |
| irqReq | output | 1 | Overflow interrupt pulse |
| wakeReq | output | 1 | Overflow wake-up pulse |

## Verification
The bench uses the default parameters: an 8-bit counter, a 3-bit prescaler select and a two-stage synchronizer. With these, an 8-bit count wraps within a few dozen stimulus clocks once the preload sits near the top. That keeps reload chains reachable in every mode. The bench sweeps interval mode over prescaler selects 0 to 3 and 7, each with preloads at 0, mid-range and near full. It compares the counts against an arithmetic reload model. Event edge selection, pulse polarity, pulse prescaling, pulse overflow, power-down and the interrupt gating are each taken through explicit edge sequences.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmrMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic inc;    // advance the counter this cycle
    logic runOn;  // run bit, selects preload write-through
  } ctlStrobe_t;
endpackage

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdFlag,
  input  logic             extPin,
  input  logic             cfgWe,
  input  logic [1:0]       cfgMode,
  input  logic [PSC_W-1:0] cfgPsc,
  input  logic             cfgEdge,
  input  logic             cfgRun,
  input  logic             cfgIrqEn,
  output ctlStrobe_t       strobe,
  output logic             runBit,
  output logic             irqEn,
  output logic [1:0]       modeSel
);
  localparam int PS_W = (1 << PSC_W) - 1;

  tmrMode_e         modeReg;
  logic [PSC_W-1:0] pscReg;
  logic             edgeReg;
  logic             runReg;
  logic             irqEnReg;

  // input synchronizer and edge detect
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinNow, pinPrev, riseEdge, fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extPin};
      pinPrev <= pinNow;
    end
  end

  assign pinNow   = syncQ[SYNC_STAGES-1];
  assign riseEdge = pinNow & ~pinPrev;
  assign fallEdge = ~pinNow & pinPrev;

  // pulse-width phase tracking
  logic pulseActive, startEdge, stopEdge, pulseDone;
  assign startEdge = edgeReg ? riseEdge : fallEdge;
  assign stopEdge  = edgeReg ? fallEdge : riseEdge;
  assign pulseDone = (modeReg == MODE_PULSE) && runReg && pulseActive && stopEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        pulseActive <= 1'b0;
    else if (modeReg != MODE_PULSE || !runReg)        pulseActive <= 1'b0;
    else if (!pulseActive && startEdge)               pulseActive <= 1'b1;
    else if (pulseActive && stopEdge)                 pulseActive <= 1'b0;
  end

  // prescaler, cleared whenever the internal clock path is idle
  logic            clkRun, tick;
  logic [PS_W-1:0] psCnt, psMask;

  assign clkRun = runReg && !pdFlag &&
                  ((modeReg == MODE_TIMER) || (modeReg == MODE_PULSE && pulseActive));

  always_comb begin
    for (int i = 0; i < PS_W; i++) psMask[i] = (i < int'(pscReg));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        psCnt <= '0;
    else if (!clkRun) psCnt <= '0;
    else              psCnt <= psCnt + PS_W'(1);
  end

  assign tick = clkRun && ((psCnt & psMask) == psMask);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= MODE_OFF;
      pscReg   <= '0;
      edgeReg  <= 1'b0;
      runReg   <= 1'b0;
      irqEnReg <= 1'b0;
    end else if (cfgWe) begin
      modeReg  <= tmrMode_e'(cfgMode);
      pscReg   <= cfgPsc;
      edgeReg  <= cfgEdge;
      runReg   <= cfgRun;
      irqEnReg <= cfgIrqEn;
    end else if (pulseDone) begin
      runReg   <= 1'b0;
    end
  end

  always_comb begin
    strobe.runOn = runReg;
    unique case (modeReg)
      MODE_EVENT: strobe.inc = runReg && (edgeReg ? fallEdge : riseEdge);
      MODE_TIMER,
      MODE_PULSE: strobe.inc = tick;
      default:    strobe.inc = 1'b0;
    endcase
  end

  assign runBit  = runReg;
  assign irqEn   = irqEnReg;
  assign modeSel = modeReg;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic             preWe,
  input  logic [CNT_W-1:0] preData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] preVal,
  output logic             ovf
);
  logic [CNT_W-1:0] cntQ, preQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      preQ <= '0;
    else if (preWe) preQ <= preData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      ovf  <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (preWe && !strobe.runOn) begin
        cntQ <= preData;
      end else if (strobe.inc) begin
        if (cntQ == '1) begin
          cntQ <= preQ;
          ovf  <= 1'b1;
        end else begin
          cntQ <= cntQ + CNT_W'(1);
        end
      end
    end
  end

  assign cntVal = cntQ;
  assign preVal = preQ;
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdFlag,
  input  logic             extPin,
  input  logic             cfgWe,
  input  logic [1:0]       cfgMode,
  input  logic [PSC_W-1:0] cfgPsc,
  input  logic             cfgEdge,
  input  logic             cfgRun,
  input  logic             cfgIrqEn,
  input  logic             preWe,
  input  logic [CNT_W-1:0] preData,
  output logic [CNT_W-1:0] cntVal,
  output logic             runBit,
  output logic             irqReq,
  output logic             wakeReq
);
  ctlStrobe_t       strobe;
  logic             irqEn, ovf;
  logic [1:0]       modeSel;
  logic [CNT_W-1:0] preVal;

  tmr_control #(.PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .pdFlag(pdFlag), .extPin(extPin),
    .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgPsc(cfgPsc), .cfgEdge(cfgEdge),
    .cfgRun(cfgRun), .cfgIrqEn(cfgIrqEn),
    .strobe(strobe), .runBit(runBit), .irqEn(irqEn), .modeSel(modeSel)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preWe(preWe), .preData(preData),
    .cntVal(cntVal), .preVal(preVal), .ovf(ovf)
  );

  assign wakeReq = ovf;
  assign irqReq  = ovf & irqEn;
endmodule

// File: rtl/tmr_evt_checker.sv
module tmr_evt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] preVal,
  input logic             runBit,
  input logic             irqReq,
  input logic             wakeReq,
  input logic             preWe,
  input logic [1:0]       modeSel
);
  // R5: interrupt only ever accompanies a wake-up
  p_irq_with_wake_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> wakeReq);

  // R4: an overflow leaves the preload value in the counter
  p_reload_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !$past(preWe)) |-> (cntVal == preVal));

  // R3: stopped counter holds unless preloaded
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !preWe) |=> $stable(cntVal));

  // R2: a running counter moves by at most one step per cycle
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && !preWe) |=> ((cntVal == $past(cntVal)) ||
                            (cntVal == $past(cntVal) + CNT_W'(1)) || wakeReq));

  // R1: mode 00 never counts
  p_mode_off_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && !preWe) |=> $stable(cntVal));
endmodule

bind tmr_evt_unit tmr_evt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntVal(cntVal), .preVal(preVal), .runBit(runBit),
  .irqReq(irqReq), .wakeReq(wakeReq), .preWe(preWe), .modeSel(modeSel)
);

// File: tb/tmr_evt_unit_bench.sv
module tmr_evt_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdFlag = 1'b0, extPin = 1'b0;
  logic cfgWe = 1'b0, cfgEdge = 1'b0, cfgRun = 1'b0, cfgIrqEn = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic [2:0] cfgPsc = 3'd0;
  logic preWe = 1'b0;
  logic [7:0] preData = 8'd0;
  logic [7:0] cntVal;
  logic runBit, irqReq, wakeReq;

  int nRun = 0, nFail = 0;
  int irqSeen = 0, wakeSeen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_evt_unit u_tmr_evt_unit (
    .clk(clk), .rstN(rstN), .pdFlag(pdFlag), .extPin(extPin),
    .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgPsc(cfgPsc), .cfgEdge(cfgEdge),
    .cfgRun(cfgRun), .cfgIrqEn(cfgIrqEn), .preWe(preWe), .preData(preData),
    .cntVal(cntVal), .runBit(runBit), .irqReq(irqReq), .wakeReq(wakeReq)
  );

  always @(negedge clk) begin
    if (irqReq)  irqSeen++;
    if (wakeReq) wakeSeen++;
  end

  task automatic check(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cntAfter(int start, int pre, int n);
    int c = start;
    for (int i = 0; i < n; i++) c = (c == 255) ? pre : c + 1;
    return c;
  endfunction

  task automatic cfg(logic [1:0] m, logic [2:0] p, logic e, logic r, logic ie);
    @(negedge clk);
    cfgMode = m; cfgPsc = p; cfgEdge = e; cfgRun = r; cfgIrqEn = ie; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic preload(logic [7:0] v);
    @(negedge clk);
    preData = v; preWe = 1'b1;
    @(negedge clk);
    preWe = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPin(logic v, int hold);
    extPin = v;
    waitCyc(hold);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : main
    int base, irqB, wakeB, held;
    int pres[3];
    pres[0] = 0; pres[1] = 200; pres[2] = 250;
    waitCyc(3);
    // R11 reset state
    check("R11 cnt", cntVal, 0);
    check("R11 run", runBit, 0);
    check("R11 irq", irqReq, 0);
    check("R11 wake", wakeReq, 0);
    rstN = 1'b1;
    waitCyc(2);

    // R2/R4: interval sweep over prescaler and preload
    for (int pi = 0; pi < 5; pi++) begin
      int p = (pi == 4) ? 7 : pi;
      int n = (pi == 4) ? 600 : 37;
      for (int k = 0; k < 3; k++) begin
        cfg(2'b10, 3'(p), 1'b0, 1'b0, 1'b0);
        preload(8'(pres[k]));
        check("R10 stopped preload loads", cntVal, pres[k]);
        cfg(2'b10, 3'(p), 1'b0, 1'b1, 1'b0);
        waitCyc(n);
        check($sformatf("R2 R4 timer psc=%0d pre=%0d", p, pres[k]), cntVal,
              cntAfter(pres[k], pres[k], n >> p));
      end
    end

    // R3: software stop holds
    cfg(2'b10, 3'd0, 1'b0, 1'b0, 1'b0);
    held = cntVal;
    waitCyc(20);
    check("R3 run cleared", runBit, 0);
    check("R3 hold when stopped", cntVal, held);

    // R10: preload while running leaves count
    preload(8'd10);
    cfg(2'b10, 3'd7, 1'b0, 1'b1, 1'b0);
    preload(8'd77);
    check("R10 running preload no load", cntVal, 10);

    // R1: mode 00 holds
    cfg(2'b00, 3'd0, 1'b0, 1'b1, 1'b0);
    held = cntVal;
    waitCyc(20);
    check("R1 mode off hold", cntVal, held);
    check("R1 run still set", runBit, 1);

    // R9: power-down halts interval mode
    cfg(2'b10, 3'd0, 1'b0, 1'b0, 1'b0);
    preload(8'd5);
    pdFlag = 1'b1;
    cfg(2'b10, 3'd0, 1'b0, 1'b1, 1'b0);
    waitCyc(20);
    check("R9 timer halted in power-down", cntVal, 5);
    pdFlag = 1'b0;

    // R6: event edge select
    cfg(2'b01, 3'd0, 1'b0, 1'b0, 1'b0);
    extPin = 1'b0; waitCyc(5);
    preload(8'd0);
    cfg(2'b01, 3'd0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin setPin(1'b1, 4); setPin(1'b0, 4); end
    check("R6 rising count", cntVal, 5);
    setPin(1'b1, 5);
    check("R6 TE0 rise counts", cntVal, 6);
    setPin(1'b0, 5);
    check("R6 TE0 fall ignored", cntVal, 6);
    cfg(2'b01, 3'd0, 1'b1, 1'b1, 1'b0);
    setPin(1'b1, 5);
    check("R6 TE1 rise ignored", cntVal, 6);
    setPin(1'b0, 5);
    check("R6 TE1 fall counts", cntVal, 7);

    // R4/R5: event overflow with interrupt on and off; R9 power-down keeps events
    cfg(2'b01, 3'd0, 1'b0, 1'b0, 1'b1);
    preload(8'd253);
    pdFlag = 1'b1;
    cfg(2'b01, 3'd0, 1'b0, 1'b1, 1'b1);
    irqB = irqSeen; wakeB = wakeSeen;
    for (int i = 0; i < 5; i++) begin setPin(1'b1, 4); setPin(1'b0, 4); end
    check("R4 R9 event reload in power-down", cntVal, cntAfter(253, 253, 5));
    check("R5 irq enabled", irqSeen - irqB, 1);
    check("R9 wake in power-down", wakeSeen - wakeB, 1);
    pdFlag = 1'b0;
    cfg(2'b01, 3'd0, 1'b0, 1'b1, 1'b0);
    irqB = irqSeen; wakeB = wakeSeen;
    for (int i = 0; i < 3; i++) begin setPin(1'b1, 4); setPin(1'b0, 4); end
    check("R4 event second reload", cntVal, cntAfter(255, 253, 3));
    check("R5 irq disabled", irqSeen - irqB, 0);
    check("R5 wake without irq", wakeSeen - wakeB, 1);

    // R7/R8: pulse width, TE=0 low pulse
    cfg(2'b11, 3'd0, 1'b0, 1'b0, 1'b0);
    setPin(1'b1, 6);
    preload(8'd0);
    cfg(2'b11, 3'd0, 1'b0, 1'b1, 1'b0);
    waitCyc(3);
    setPin(1'b0, 13); setPin(1'b1, 6);
    check("R7 low pulse width", cntVal, 13);
    check("R8 run self-cleared", runBit, 0);
    setPin(1'b0, 5); setPin(1'b1, 6);
    check("R8 later pulse ignored", cntVal, 13);

    // R7: prescaled pulse
    preload(8'd0);
    cfg(2'b11, 3'd2, 1'b0, 1'b1, 1'b0);
    waitCyc(3);
    setPin(1'b0, 22); setPin(1'b1, 6);
    check("R7 prescaled pulse", cntVal, 22 >> 2);

    // R7: TE=1 high pulse
    cfg(2'b11, 3'd0, 1'b1, 1'b0, 1'b0);
    setPin(1'b0, 6);
    preload(8'd0);
    cfg(2'b11, 3'd0, 1'b1, 1'b1, 1'b0);
    waitCyc(3);
    setPin(1'b1, 9); setPin(1'b0, 6);
    check("R7 high pulse width", cntVal, 9);
    check("R8 run cleared TE1", runBit, 0);

    // R4: pulse-mode overflow
    preload(8'd250);
    wakeB = wakeSeen;
    cfg(2'b11, 3'd0, 1'b1, 1'b1, 1'b0);
    waitCyc(3);
    setPin(1'b1, 10); setPin(1'b0, 6);
    check("R4 pulse reload", cntVal, cntAfter(250, 250, 10));
    check("R5 pulse wake", wakeSeen - wakeB, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule